// File: doc/BRIEF.md
# Return-label flow guard

The flow guard sits behind the retire stage of a processor and enforces a label protocol on calls and returns. Each retired instruction arrives as a class code with a label operand. After a call, the very next retired instruction must be a label-enter. That instruction marks its label as live and brings the guard back to normal running. After a return, the very next retired instruction must be a label-check that names a live label. A label-drop marks a label as no longer live.

Any break in this protocol sends the guard into a terminal halt state. In that state it raises a halt request that stays high until reset, and it pulses an attack flag for one cycle. The live-label table is a bit vector indexed by the label operand. After reset only label 0 is live, which stands for the top-level function.

Top module: `flow_guard`

## Requirements
- R1: After reset, state_o is 0 (normal), halt_o and attack_o are 0, label 0 is live and every other label is not live.
- R2: In normal state, a valid retire of class 1 (direct call) or class 2 (indirect call) moves state_o to 1 (entry) on the next cycle.
- R3: In entry state, a valid class 4 (label-enter) makes its label live and moves state_o to 0.
- R4: In entry state, a valid retire of any class other than 4 moves state_o to 3 (halt).
- R5: In normal state, a valid class 3 (return) moves state_o to 2 (exit).
- R6: In exit state, a valid class 6 (label-check) whose label is live moves state_o to 0 and leaves the table unchanged.
- R7: In exit state, a valid retire that is not class 6, or a class 6 whose label is not live, moves state_o to 3.
- R8: A valid class 5 (label-drop) in normal state makes its label not live.
- R9: A label-enter on a label that is already live leaves it live.
- R10: In normal state, classes 4, 5 and 6 and class 0 (other) keep state_o at 0. Class 6 there does not change the table.
- R11: Once state_o is 3, halt_o stays 1 and state_o stays 3 until reset, whatever retires. attack_o is 1 only in the first cycle of halt.
- R12: A cycle with ret_valid low changes neither the state nor the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A retire event is present this cycle |
| ret_class | input | 3 | Retire class: 0 other, 1 direct call, 2 indirect call, 3 return, 4 label-enter, 5 label-drop, 6 label-check, 7 treated as other |
| ret_label | input | LABEL_W | Label operand of the retired instruction |
| state_o | output | 2 | Guard state: 0 normal, 1 entry, 2 exit, 3 halt |
| halt_o | output | 1 | Halt request, held until reset |
| attack_o | output | 1 | One-cycle pulse when an attack is detected |

## Verification
The bench checks the table only through behaviour at the ports. A return followed by a check on a label passes when the label is live and halts when it is not. Because of this, a table that ignored label-drop, or that cleared label 0 at reset, would let a forbidden return pass or halt a legal one. The corner cases cover several faults. A label-drop or a second return placed right after a call or a return must halt; a guard that checked only for "some label instruction" would let these through. An idle cycle inside the entry and exit states must not count as the missing instruction. A halted guard must ignore a well-formed enter or check, which a non-sticky halt would wrongly accept. The attack pulse must fall after one cycle while the halt request stays high.

// File: rtl/flow_guard_pkg.sv
package flow_guard_pkg;
   typedef enum logic [2:0] {
      RC_OTHER     = 3'd0,
      RC_CALL_DIR  = 3'd1,
      RC_CALL_IND  = 3'd2,
      RC_RETURN    = 3'd3,
      RC_LBL_ENTER = 3'd4,
      RC_LBL_DROP  = 3'd5,
      RC_LBL_CHECK = 3'd6,
      RC_RSVD      = 3'd7
   } ret_class_e;

   typedef enum logic [1:0] {
      FG_NORMAL = 2'd0,
      FG_ENTRY  = 2'd1,
      FG_EXIT   = 2'd2,
      FG_HALT   = 2'd3
   } fg_state_e;
endpackage

// File: rtl/flow_guard_labels.sv
module flow_guard_labels #(
   parameter int LABEL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [LABEL_W-1:0] wr_label,
   input  logic [LABEL_W-1:0] rd_label,
   output logic               rd_hit
);
   localparam int DEPTH = 1 << LABEL_W;

   logic [DEPTH-1:0] live_vec;

   if (LABEL_W < 1 || LABEL_W > 10) begin : g_bad_width
      $error("flow_guard_labels: LABEL_W must lie in 1..10");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      localparam logic RST_VAL = (i == 0);
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= RST_VAL;
         else if (set_en && (wr_label == LABEL_W'(i)))
            bit_q <= 1'b1;
         else if (clr_en && (wr_label == LABEL_W'(i)))
            bit_q <= 1'b0;
      end
      assign live_vec[i] = bit_q;
   end

   assign rd_hit = live_vec[rd_label];

   // R3
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> live_vec[$past(wr_label)]);
   // R8
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !live_vec[$past(wr_label)]);
   // R12
   table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(live_vec));
endmodule

// File: rtl/flow_guard_fsm.sv
module flow_guard_fsm
   import flow_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_valid,
   input  logic [2:0] ev_class,
   input  logic       lbl_hit,
   output logic       set_en,
   output logic       clr_en,
   output logic [1:0] state_o,
   output logic       halt_o,
   output logic       attack_o
);
   fg_state_e state_q, state_d;
   logic      attack_q;

   always_comb begin
      state_d = state_q;
      set_en  = 1'b0;
      clr_en  = 1'b0;
      if (ev_valid) begin
         unique case (state_q)
            FG_NORMAL: begin
               unique case (ev_class)
                  RC_CALL_DIR, RC_CALL_IND: state_d = FG_ENTRY;
                  RC_RETURN:                state_d = FG_EXIT;
                  RC_LBL_ENTER:             set_en  = 1'b1;
                  RC_LBL_DROP:              clr_en  = 1'b1;
                  default:                  ;
               endcase
            end
            FG_ENTRY: begin
               if (ev_class == RC_LBL_ENTER) begin
                  set_en  = 1'b1;
                  state_d = FG_NORMAL;
               end else begin
                  state_d = FG_HALT;
               end
            end
            FG_EXIT: begin
               if ((ev_class == RC_LBL_CHECK) && lbl_hit)
                  state_d = FG_NORMAL;
               else
                  state_d = FG_HALT;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= FG_NORMAL;
         attack_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         attack_q <= (state_d == FG_HALT) && (state_q != FG_HALT);
      end
   end

   assign state_o  = state_q;
   assign halt_o   = (state_q == FG_HALT);
   assign attack_o = attack_q;

   // R11
   halt_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);
   // R11
   attack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attack_o |-> (halt_o && !$past(halt_o)));
   // R2
   call_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FG_NORMAL && ev_valid &&
       (ev_class == RC_CALL_DIR || ev_class == RC_CALL_IND)) |=> state_q == FG_ENTRY);
   // R4
   entry_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FG_ENTRY && ev_valid && ev_class != RC_LBL_ENTER) |=> halt_o);
   // R6
   exit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FG_EXIT && ev_valid && ev_class == RC_LBL_CHECK && lbl_hit)
      |=> state_q == FG_NORMAL);
   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(state_q));
endmodule

// File: rtl/flow_guard.sv
module flow_guard #(
   parameter int LABEL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ret_valid,
   input  logic [2:0]         ret_class,
   input  logic [LABEL_W-1:0] ret_label,
   output logic [1:0]         state_o,
   output logic               halt_o,
   output logic               attack_o
);
   logic set_en, clr_en, lbl_hit;

   flow_guard_labels #(.LABEL_W(LABEL_W)) u_labels (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .clr_en   (clr_en),
      .wr_label (ret_label),
      .rd_label (ret_label),
      .rd_hit   (lbl_hit)
   );

   flow_guard_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ret_valid),
      .ev_class (ret_class),
      .lbl_hit  (lbl_hit),
      .set_en   (set_en),
      .clr_en   (clr_en),
      .state_o  (state_o),
      .halt_o   (halt_o),
      .attack_o (attack_o)
   );

   // R10
   normal_cfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && ret_valid && (ret_class == 3'd4 || ret_class == 3'd5 ||
       ret_class == 3'd6 || ret_class == 3'd0)) |=> state_o == 2'd0);
endmodule

// File: tb/flow_guard_bench.sv
module flow_guard_bench;
   localparam int LW = 6;
   localparam int NV = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ret_valid = 1'b0;
   logic [2:0]    ret_class = 3'd0;
   logic [LW-1:0] ret_label = '0;
   logic [1:0]    state_o;
   logic          halt_o, attack_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   flow_guard #(.LABEL_W(LW)) u_flow_guard (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_class(ret_class),
      .ret_label(ret_label), .state_o(state_o), .halt_o(halt_o), .attack_o(attack_o)
   );

   always #10 clk = ~clk;

   // entry: valid, class, label, expected state, expected attack
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 3'd1, 6'd0,  2'd1, 1'b0},  // R2 direct call
      {1'b1, 3'd4, 6'd5,  2'd0, 1'b0},  // R3 enter 5
      {1'b1, 3'd3, 6'd0,  2'd2, 1'b0},  // R5 return
      {1'b1, 3'd6, 6'd5,  2'd0, 1'b0},  // R6 check 5
      {1'b1, 3'd2, 6'd0,  2'd1, 1'b0},  // R2 indirect call
      {1'b1, 3'd4, 6'd5,  2'd0, 1'b0},  // R9 enter 5 again
      {1'b1, 3'd3, 6'd0,  2'd2, 1'b0},  // R5
      {1'b1, 3'd6, 6'd0,  2'd0, 1'b0},  // R1 label 0 live
      {1'b1, 3'd4, 6'd9,  2'd0, 1'b0},  // R10 enter in normal
      {1'b1, 3'd3, 6'd0,  2'd2, 1'b0},  // R5
      {1'b1, 3'd6, 6'd9,  2'd0, 1'b0},  // R10 enter took effect
      {1'b1, 3'd6, 6'd7,  2'd0, 1'b0},  // R10 check in normal
      {1'b1, 3'd0, 6'd0,  2'd0, 1'b0},  // R10 other
      {1'b0, 3'd1, 6'd0,  2'd0, 1'b0},  // R12 idle call
      {1'b1, 3'd3, 6'd0,  2'd2, 1'b0},  // R5
      {1'b0, 3'd0, 6'd0,  2'd2, 1'b0},  // R12 idle in exit
      {1'b1, 3'd6, 6'd5,  2'd0, 1'b0},  // R9 5 still live
      {1'b1, 3'd7, 6'd0,  2'd0, 1'b0}   // R10 reserved as other
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic [LW-1:0] l);
      @(negedge clk);
      ret_valid = v; ret_class = c; ret_label = l;
      @(posedge clk);
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ret_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic expect_halt(input string tag);
      check({tag, " state"}, state_o, 3);
      check({tag, " halt"}, halt_o, 1);
      check({tag, " attack"}, attack_o, 1);
   endtask

   initial begin
      do_reset();
      #2;
      check("R1 state", state_o, 0);
      check("R1 halt", halt_o, 0);
      check("R1 attack", attack_o, 0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][12], VEC[i][11:9], VEC[i][8:3]);
         check($sformatf("vec%0d state", i), state_o, VEC[i][2:1]);
         check($sformatf("vec%0d attack", i), attack_o, VEC[i][0]);
      end

      // R4 other after call, then R11 stickiness
      do_reset();
      step(1, 3'd1, 0);
      step(1, 3'd0, 0);
      expect_halt("R4 other");
      step(1, 3'd4, 3);
      check("R11 attack falls", attack_o, 0);
      check("R11 halt held", halt_o, 1);
      step(1, 3'd3, 0);
      step(1, 3'd6, 0);
      check("R11 state held", state_o, 3);
      step(0, 3'd0, 0);
      check("R11 halt idle", halt_o, 1);
      do_reset();
      #2;
      check("R1 after halt", state_o, 0);
      check("R1 halt cleared", halt_o, 0);

      // R4 drop right after call
      do_reset();
      step(1, 3'd1, 0);
      step(1, 3'd5, 0);
      expect_halt("R4 drop");

      // R12 idle in entry, then enter
      do_reset();
      step(1, 3'd2, 0);
      step(0, 3'd0, 0);
      check("R12 idle entry", state_o, 1);
      step(1, 3'd4, 12);
      check("R3 enter", state_o, 0);

      // R7 check on inactive label
      do_reset();
      step(1, 3'd3, 0);
      step(1, 3'd6, 33);
      expect_halt("R7 inactive");

      // R1 label 1 not live after reset
      do_reset();
      step(1, 3'd3, 0);
      step(1, 3'd6, 1);
      expect_halt("R1 label1");

      // R7 missing check
      do_reset();
      step(1, 3'd3, 0);
      step(1, 3'd0, 0);
      expect_halt("R7 missing");

      // R7 second return
      do_reset();
      step(1, 3'd3, 0);
      step(1, 3'd3, 0);
      expect_halt("R7 ret ret");

      // R8 drop clears label
      do_reset();
      step(1, 3'd4, 9);
      step(1, 3'd5, 9);
      check("R8 state", state_o, 0);
      step(1, 3'd3, 0);
      step(1, 3'd6, 9);
      expect_halt("R8 dropped");

      // R8 drop label 0
      do_reset();
      step(1, 3'd5, 0);
      step(1, 3'd3, 0);
      step(1, 3'd6, 0);
      expect_halt("R8 root");

      // R6 table unchanged by passing check
      do_reset();
      step(1, 3'd3, 0);
      step(1, 3'd6, 0);
      step(1, 3'd3, 0);
      step(1, 3'd6, 0);
      check("R6 repeat", state_o, 0);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule